// File: doc/BRIEF.md
# Hybrid Concatenated Convolutional Encoder

This block turns a frame of message bits into coded groups. It uses three identical four-state recursive systematic convolutional encoders. The first encoder codes the message in arrival order. The second codes a permuted copy of the message, which is the parallel branch. The third codes a permuted copy of the first encoder's parity stream, which is the serial branch. Each message bit yields one output group that carries the systematic bit and the three parity bits. A build option removes parity bits so that three of the four bits are sent.

A frame is loaded one bit per accepted cycle. The bit that carries the start flag becomes bit 0. Once the last bit is in, the input stalls and the block replays both frame buffers. The natural-order reads give the systematic and first-parity bits. The permuted reads drive the second and third encoders. Groups leave on consecutive cycles. No termination tail is added: the final state of each encoder is presented at the block's ports.

Top module: `hcc_encoder`

## Requirements
- R1: Each component encoder holds state (d1, d2), which is all-zero at the start of each frame. For an input bit u it forms a = u ^ d1 ^ d2, emits parity a ^ d2, and moves to (a, d1).
- R2: `in_ready` is high while the block loads or waits for a frame. It is low from the cycle after the last bit of a frame is accepted until the cycle that shows the final group. Inputs presented while it is low have no effect.
- R3: An accepted bit with `in_start` high becomes bit 0 of a new frame, including when a frame is partly loaded. An accepted bit without `in_start` while no frame is open is discarded.
- R4: After the last bit is accepted, FRAME_LEN groups appear on consecutive cycles, and the first one appears two cycles after that acceptance.
- R5: Group k has these bit positions: [3] is message bit k; [2] is the first encoder's parity at step k; [1] is the second encoder's parity at step k; [0] is the third encoder's parity at step k.
- R6: At step k the second encoder reads message bit A(k) = (ILV_A_F1*k + ILV_A_F2*k*k) mod FRAME_LEN. The third encoder reads first-encoder parity bit B(k), the same polynomial with the ILV_B coefficients.
- R7: `out_last` is high with group FRAME_LEN-1 and with no other group.
- R8: From the cycle `out_last` is high, `end_state1`, `end_state2` and `end_state3` show each encoder's state after its final bit, as {d2, d1}. Each value holds until that encoder starts its next frame.
- R9: With PUNCTURE=0, `out_keep` is 4'b1111. With PUNCTURE=1, `out_keep` is 4'b1110 on even k and 4'b1101 on odd k, and the dropped position of `out_group` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit present |
| in_start | input | 1 | Input bit is the first bit of a frame |
| in_bit | input | 1 | Message bit |
| in_ready | output | 1 | Block can take an input bit |
| out_valid | output | 1 | Output group present |
| out_group | output | 4 | Systematic, p1, p2, p3 (bit 3 down to 0) |
| out_keep | output | 4 | Positions of out_group that are transmitted |
| out_last | output | 1 | Final group of the frame |
| end_state1 | output | 2 | Final state of the first encoder |
| end_state2 | output | 2 | Final state of the second encoder |
| end_state3 | output | 2 | Final state of the third encoder |

## Verification
The assertions assume the interleaver coefficients are legal: the first coefficient is odd and the second even, so every step of the address increment is odd and each index map is a permutation. They also assume the source never counts on a bit being taken while `in_ready` is low. The bench presents real frame bits only when it sees `in_ready` high. It deliberately drives junk, with and without the start flag, during the replay pass and while idle, and it stops that junk before the replay pass ends, so the only accepted bits are the ones the model expects.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

   // state bit 0 = one-cycle delay (d1), bit 1 = two-cycle delay (d2)
   typedef logic [1:0] rsc_state_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_EMIT = 2'd2
   } phase_t;

   localparam int GRP_W   = 4;
   localparam int POS_SYS = 3;
   localparam int POS_P1  = 2;
   localparam int POS_P2  = 1;
   localparam int POS_P3  = 0;

   // feedback 1+D+D^2
   function automatic logic rsc_fb(input rsc_state_t s, input logic u);
      return u ^ s[0] ^ s[1];
   endfunction

   // feedforward 1+D^2
   function automatic logic rsc_par(input rsc_state_t s, input logic u);
      return rsc_fb(s, u) ^ s[1];
   endfunction

   function automatic rsc_state_t rsc_next(input rsc_state_t s, input logic u);
      return {s[0], rsc_fb(s, u)};
   endfunction

endpackage

// File: rtl/hcc_rsc.sv
module hcc_rsc
   import hcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       u,
   output logic       parity,
   output rsc_state_t state
);

   rsc_state_t s_eff;

   // clearing and consuming in one cycle codes the bit from the zero state
   assign s_eff  = clr ? '0 : state;
   assign parity = rsc_par(s_eff, u);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
      end else if (en) begin
         state <= rsc_next(s_eff, u);
      end else if (clr) begin
         state <= '0;
      end
   end

   // R1
   rsc_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> state[1] == $past(state[0]));

   // R1
   rsc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !en) |=> state == '0);

   // R1
   rsc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> state[0] == ($past(parity) ^ $past(state[1])));

endmodule

// File: rtl/hcc_qpp_gen.sv
module hcc_qpp_gen #(
   parameter int N  = 64,
   parameter int F1 = 7,
   parameter int F2 = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 advance,
   output logic [$clog2(N)-1:0] idx
);

   localparam int AW = $clog2(N);
   localparam logic [AW-1:0] STEP0 = AW'((F1 + F2) % N);
   localparam logic [AW-1:0] DSTEP = AW'((2 * F2) % N);

   if ((F1 % 2) != 1) begin : g_bad_f1
      $error("hcc_qpp_gen: F1 must be odd");
   end
   if ((F2 % 2) != 0) begin : g_bad_f2
      $error("hcc_qpp_gen: F2 must be even");
   end

   logic [AW-1:0] step;

   // pi(k+1) = pi(k) + g(k); g(k+1) = g(k) + 2*F2; mod N by truncation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         step <= STEP0;
      end else if (restart) begin
         idx  <= '0;
         step <= STEP0;
      end else if (advance) begin
         idx  <= idx + step;
         step <= step + DSTEP;
      end
   end

   // R6
   qpp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> idx == '0);

   // R6
   qpp_step_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step[0] == 1'b1);

   // R6
   qpp_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart) |=> idx != $past(idx));

endmodule

// File: rtl/hcc_pmux.sv
module hcc_pmux
   import hcc_pkg::*;
#(
   parameter bit PUNCTURE = 1'b0
) (
   input  logic             sys,
   input  logic             p1,
   input  logic             p2,
   input  logic             p3,
   input  logic             odd,
   output logic [GRP_W-1:0] grp,
   output logic [GRP_W-1:0] keep
);

   if (PUNCTURE) begin : g_punct
      always_comb begin
         keep          = '1;
         keep[POS_P2]  = ~odd;
         keep[POS_P3]  = odd;
         grp           = '0;
         grp[POS_SYS]  = sys;
         grp[POS_P1]   = p1;
         grp[POS_P2]   = p2 & ~odd;
         grp[POS_P3]   = p3 & odd;
      end
   end else begin : g_full
      logic unused_odd;
      assign unused_odd = odd;
      always_comb begin
         keep          = '1;
         grp           = '0;
         grp[POS_SYS]  = sys;
         grp[POS_P1]   = p1;
         grp[POS_P2]   = p2;
         grp[POS_P3]   = p3;
      end
   end

endmodule

// File: rtl/hcc_encoder.sv
module hcc_encoder
   import hcc_pkg::*;
#(
   parameter int FRAME_LEN = 64,
   parameter int ILV_A_F1  = 7,
   parameter int ILV_A_F2  = 16,
   parameter int ILV_B_F1  = 13,
   parameter int ILV_B_F2  = 40,
   parameter bit PUNCTURE  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_start,
   input  logic       in_bit,
   output logic       in_ready,
   output logic       out_valid,
   output logic [3:0] out_group,
   output logic [3:0] out_keep,
   output logic       out_last,
   output logic [1:0] end_state1,
   output logic [1:0] end_state2,
   output logic [1:0] end_state3
);

   localparam int AW = $clog2(FRAME_LEN);
   localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);
   localparam int KEEP_ONES = PUNCTURE ? 3 : 4;

   if (FRAME_LEN < 4 || (FRAME_LEN & (FRAME_LEN - 1)) != 0) begin : g_bad_len
      $error("hcc_encoder: FRAME_LEN must be a power of two, at least 4");
   end

   phase_t         phase;
   logic [AW-1:0]  cnt;
   logic [FRAME_LEN-1:0] msg_buf;
   logic [FRAME_LEN-1:0] par_buf;

   logic           take, store, first, enter_emit, emitting;
   logic [AW-1:0]  wr_idx;
   logic [AW-1:0]  idx_a, idx_b;
   logic           p1_in, p1_rd, sys_rd, u2, u3, p2, p3;
   logic [GRP_W-1:0] grp_c, keep_c;
   rsc_state_t     st1, st2, st3;

   // ---------------- load side ----------------
   assign in_ready   = (phase != PH_EMIT);
   assign emitting   = (phase == PH_EMIT);
   assign take       = in_valid && in_ready;
   assign first      = take && in_start;
   assign store      = take && (in_start || phase == PH_LOAD);
   assign wr_idx     = in_start ? '0 : cnt;
   assign enter_emit = store && (wr_idx == LAST_IDX);

   hcc_rsc u_enc1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (first),
      .en     (store),
      .u      (in_bit),
      .parity (p1_in),
      .state  (st1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         msg_buf <= '0;
         par_buf <= '0;
      end else if (emitting) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST_IDX) begin
            phase <= PH_IDLE;
            cnt   <= '0;
         end
      end else if (store) begin
         msg_buf[wr_idx] <= in_bit;
         par_buf[wr_idx] <= p1_in;
         if (wr_idx == LAST_IDX) begin
            phase <= PH_EMIT;
            cnt   <= '0;
         end else begin
            phase <= PH_LOAD;
            cnt   <= wr_idx + 1'b1;
         end
      end
   end

   // ---------------- permuted replay ----------------
   hcc_qpp_gen #(.N(FRAME_LEN), .F1(ILV_A_F1), .F2(ILV_A_F2)) u_ilv_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (enter_emit),
      .advance (emitting),
      .idx     (idx_a)
   );

   hcc_qpp_gen #(.N(FRAME_LEN), .F1(ILV_B_F1), .F2(ILV_B_F2)) u_ilv_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (enter_emit),
      .advance (emitting),
      .idx     (idx_b)
   );

   assign sys_rd = msg_buf[cnt];
   assign p1_rd  = par_buf[cnt];
   assign u2     = msg_buf[idx_a];
   assign u3     = par_buf[idx_b];

   hcc_rsc u_enc2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (enter_emit),
      .en     (emitting),
      .u      (u2),
      .parity (p2),
      .state  (st2)
   );

   hcc_rsc u_enc3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (enter_emit),
      .en     (emitting),
      .u      (u3),
      .parity (p3),
      .state  (st3)
   );

   hcc_pmux #(.PUNCTURE(PUNCTURE)) u_pmux (
      .sys  (sys_rd),
      .p1   (p1_rd),
      .p2   (p2),
      .p3   (p3),
      .odd  (cnt[0]),
      .grp  (grp_c),
      .keep (keep_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_group <= '0;
         out_keep  <= '0;
      end else begin
         out_valid <= emitting;
         out_last  <= emitting && (cnt == LAST_IDX);
         if (emitting) begin
            out_group <= grp_c;
            out_keep  <= keep_c;
         end
      end
   end

   assign end_state1 = {st1[1], st1[0]};
   assign end_state2 = {st2[1], st2[0]};
   assign end_state3 = {st3[1], st3[0]};

   // ---------------- checks ----------------
   logic [AW-1:0] grp_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   grp_seen <= '0;
      else if (out_valid && out_last) grp_seen <= '0;
      else if (out_valid)           grp_seen <= grp_seen + 1'b1;
   end

   // R2
   stall_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);

   // R2
   enter_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_emit |=> !in_ready);

   // R4
   burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R4
   first_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_emit |=> !out_valid ##1 out_valid);

   // R7
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R7
   last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> grp_seen == LAST_IDX);

   // R8
   end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!emitting && !enter_emit) |=> $stable(end_state2) && $stable(end_state3));

   // R9
   keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_keep) == KEEP_ONES);

   // R9
   drop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_group & ~out_keep) == '0);

   // R9
   keep_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PUNCTURE && out_valid && !out_last) |=> out_keep != $past(out_keep));

endmodule

// File: tb/hcc_encoder_bench.sv
module hcc_encoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int AF1 = 5;
   localparam int AF2 = 6;
   localparam int BF1 = 3;
   localparam int BF2 = 10;

   typedef struct packed {
      logic [3:0] grp;
      logic [3:0] keep;
      logic       last;
      logic [5:0] ends;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_start = 1'b0, in_bit = 1'b0;

   logic       rdy0, ov0, ol0, rdy1, ov1, ol1;
   logic [3:0] og0, ok0, og1, ok1;
   logic [1:0] a0, b0, c0, a1, b1, c1;

   int checks = 0;
   int fails  = 0;
   bit timeout = 1'b0;
   item_t q0[$];
   item_t q1[$];
   logic mid0 = 1'b0, mid1 = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hcc_encoder #(.FRAME_LEN(N), .ILV_A_F1(AF1), .ILV_A_F2(AF2),
                 .ILV_B_F1(BF1), .ILV_B_F2(BF2), .PUNCTURE(1'b0)) u_hcc_encoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_bit(in_bit), .in_ready(rdy0), .out_valid(ov0), .out_group(og0),
      .out_keep(ok0), .out_last(ol0), .end_state1(a0), .end_state2(b0),
      .end_state3(c0));

   hcc_encoder #(.FRAME_LEN(N), .ILV_A_F1(AF1), .ILV_A_F2(AF2),
                 .ILV_B_F1(BF1), .ILV_B_F2(BF2), .PUNCTURE(1'b1)) u_hcc_encoder_punct (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_bit(in_bit), .in_ready(rdy1), .out_valid(ov1), .out_group(og1),
      .out_keep(ok1), .out_last(ol1), .end_state1(a1), .end_state2(b1),
      .end_state3(c1));

   function automatic int ilv(input int f1, input int f2, input int k);
      return (f1 * k + f2 * k * k) % N;
   endfunction

   // reference model from R1, R5, R6, R7, R8, R9
   task automatic push_frame(input logic [N-1:0] m);
      logic [N-1:0] p1, p2, p3;
      logic [1:0] s1, s2, s3;
      logic a, u;
      item_t it;
      s1 = 2'b00; s2 = 2'b00; s3 = 2'b00;
      for (int k = 0; k < N; k++) begin
         a = m[k] ^ s1[0] ^ s1[1];
         p1[k] = a ^ s1[1];
         s1 = {s1[0], a};
      end
      for (int k = 0; k < N; k++) begin
         u = m[ilv(AF1, AF2, k)];
         a = u ^ s2[0] ^ s2[1];
         p2[k] = a ^ s2[1];
         s2 = {s2[0], a};
         u = p1[ilv(BF1, BF2, k)];
         a = u ^ s3[0] ^ s3[1];
         p3[k] = a ^ s3[1];
         s3 = {s3[0], a};
      end
      for (int k = 0; k < N; k++) begin
         it.last = (k == N - 1);
         it.ends = {s1[1], s1[0], s2[1], s2[0], s3[1], s3[0]};
         it.grp  = {m[k], p1[k], p2[k], p3[k]};
         it.keep = 4'b1111;
         q0.push_back(it);
         it.keep = (k % 2 == 0) ? 4'b1110 : 4'b1101;
         it.grp  = {m[k], p1[k], p2[k] & (k % 2 == 0), p3[k] & (k % 2 == 1)};
         q1.push_back(it);
      end
   endtask

   task automatic fail_line(input string msg);
      fails++;
      $display("FAIL %s", msg);
   endtask

   task automatic mon(input int id, input logic v, input logic [3:0] g,
                      input logic [3:0] kp, input logic l, input logic [5:0] e,
                      input logic rdy, ref item_t q[$], ref logic mid);
      item_t it;
      if (mid) begin
         checks++;
         if (!v) fail_line($sformatf("R4 dut%0d gap in group burst: valid=%b expected 1", id, v));
      end
      if (v) begin
         if (!l) begin
            checks++;
            if (rdy !== 1'b0)
               fail_line($sformatf("R2 dut%0d ready during replay: %b expected 0", id, rdy));
         end
         checks++;
         if (q.size() == 0) begin
            fail_line($sformatf("R4 dut%0d unexpected group %b expected none", id, g));
         end else begin
            it = q.pop_front();
            if (g !== it.grp)
               fail_line($sformatf("R1 R5 R6 dut%0d group %b expected %b", id, g, it.grp));
            if (kp !== it.keep)
               fail_line($sformatf("R9 dut%0d keep %b expected %b", id, kp, it.keep));
            if (l !== it.last)
               fail_line($sformatf("R7 dut%0d last %b expected %b", id, l, it.last));
            if (it.last) begin
               checks++;
               if (e !== it.ends)
                  fail_line($sformatf("R8 dut%0d end states %b expected %b", id, e, it.ends));
            end
         end
      end
      mid = v && !l;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         mon(0, ov0, og0, ok0, ol0, {a0, b0, c0}, rdy0, q0, mid0);
         mon(1, ov1, og1, ok1, ol1, {a1, b1, c1}, rdy1, q1, mid1);
      end
   end

   task automatic send_frame(input logic [N-1:0] m);
      push_frame(m);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         while (!rdy0) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_start = (k == 0);
         in_bit   = m[k];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
   endtask

   task automatic junk(input int cycles, input logic st);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_start = st;
         in_bit   = i[0];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      checks++;
      if (rdy0 !== 1'b1 || ov0 !== 1'b0 || ol0 !== 1'b0)
         fail_line($sformatf("R2 reset ready/valid/last %b%b%b expected 100", rdy0, ov0, ol0));
      checks++;
      if ({a0, b0, c0} !== 6'b0)
         fail_line($sformatf("R1 reset states %b expected 000000", {a0, b0, c0}));

      send_frame(16'hA5C3);
      // R3: bits without start while no frame is open are discarded
      repeat (N + 4) @(negedge clk);
      junk(3, 1'b0);
      send_frame(16'h0001);
      // R2: start-flagged junk during replay has no effect
      send_frame(16'hFFFF);
      junk(6, 1'b1);
      // R3: a partial frame restarted by a new start bit
      @(negedge clk);
      while (!rdy0) @(negedge clk);
      junk(5, 1'b1);
      send_frame(16'h7E18);
      send_frame(16'h0000);
      send_frame(16'h8000);
      send_frame(16'h3C96);

      for (int i = 0; i < 4 * N && (q0.size() != 0 || q1.size() != 0); i++)
         @(negedge clk);
      repeat (3) @(negedge clk);
      checks++;
      if (q0.size() != 0 || q1.size() != 0)
         fail_line($sformatf("R4 groups missing %0d/%0d expected 0/0", q0.size(), q1.size()));
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) begin
         checks++;
         fail_line("R4 watchdog expired: done=0 expected 1");
      end
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule